// File: doc/BRIEF.md
# Register Access Guard

This block sits in front of a register file and decides, for every read or write aimed at a register index, whether the access may proceed. It keeps a small table of guard slots. Each slot describes one naturally aligned, power-of-two-sized span of register indexes. A slot can lock writes only, which suits mixed-use regions where reads must stay open, or it can lock both reads and writes.

Slots are loaded through a configuration port, one 32-bit word per write. The base field of a word is a byte address, and the index it names is that address with its two low bits dropped. The base does not have to be a multiple of the span length. The block clears the low log2(length) bits of the base, so a misaligned request silently moves down to the aligned span that contains it.

Each request carries an index and a direction. All slots are compared at once, and the verdict is registered one cycle later. A refused access also raises a one-cycle fault pulse that reports the index and direction. It sets a sticky flag that stays up until software clears it.

Top module: `regguard_top`

## Requirements
- R1: After reset every slot is empty, no access is refused, and rsp_valid, rsp_block, fault_pulse and fault_sticky are all 0.
- R2: A configuration word is decoded as follows. Bit 29 is the write lock. Bit 30 is the read lock. Bits 28:24 hold log2 of the span length. Bits 19:2 hold the base index. Bits 31, 23:20 and 1:0 have no effect.
- R3: When a slot covers the index and has bit 29 set, a write is refused. A read is still allowed if bit 30 of that slot is clear.
- R4: A read is refused only by a covering slot that has both bit 29 and bit 30 set. A slot with bit 30 alone, or with neither bit, never refuses anything.
- R5: A slot covers the indexes from its base with the low log2-length bits cleared up to that value plus 2^log2-length minus 1. A log2 length of 18 or more covers every index.
- R6: An access is refused when any slot refuses it. A slot that does not refuse never overrides another slot that does.
- R7: rsp_valid is high exactly one cycle after a cycle with req_valid high. rsp_block is high only together with rsp_valid.
- R8: In the same cycle as a refusal, fault_pulse is high and fault_idx and fault_write carry the refused index and direction. fault_pulse is low after any cycle without a refused request.
- R9: fault_sticky rises together with fault_pulse and stays high until sticky_clr is sampled high. A refusal in the same cycle as sticky_clr keeps it high.
- R10: A configuration write whose slot number is NUM_SLOTS or higher changes nothing.
- R11: A configuration write takes effect for requests in later cycles. A request sampled in the same cycle as the write is judged against the previous contents.
- R12: Writing an all-zero word to a slot removes its protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load a configuration word into a slot |
| cfg_slot | input | CFG_SLOT_W | Slot number to load |
| cfg_word | input | 32 | Slot configuration word |
| req_valid | input | 1 | An access request is present |
| req_idx | input | 18 | Register index of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| sticky_clr | input | 1 | Write-one-to-clear for fault_sticky |
| rsp_valid | output | 1 | Verdict for the previous cycle's request |
| rsp_block | output | 1 | The access was refused |
| fault_pulse | output | 1 | One-cycle refusal report |
| fault_idx | output | 18 | Index of the latest refused access |
| fault_write | output | 1 | Direction of the latest refused access |
| fault_sticky | output | 1 | A refusal happened since the last clear |

## Verification
The bench builds the block with NUM_SLOTS=6 and CFG_SLOT_W=3. With these values slot numbers 6 and 7 can be addressed but do not exist, which lets the bench show that writes to them are dropped. The small table also fills quickly, so random configuration writes produce overlapping slots with mixed lock modes. Random bases and indexes are kept within a few hundred registers so that spans of 2^0 to 2^8 hit often. A few slots get a log2 length of 18 or more to exercise full-range coverage.

// File: rtl/regguard_pkg.sv
package regguard_pkg;

    localparam int WORD_W   = 32;
    localparam int IDX_W    = 18;
    localparam int LG_W     = 5;
    localparam int RD_BIT   = 30;
    localparam int WR_BIT   = 29;
    localparam int LG_LSB   = 24;
    localparam int BASE_LSB = 2;
    localparam int BASE_MSB = BASE_LSB + IDX_W - 1;

    typedef logic [IDX_W-1:0] idx_t;

    // decoded guard slot, only the bits that matter are stored
    typedef struct packed {
        logic            rd_lock;
        logic            wr_lock;
        logic [LG_W-1:0] lg;
        idx_t            base;
    } slot_t;

    function automatic slot_t unpack_word(input logic [WORD_W-1:0] w);
        slot_t s;
        s.rd_lock = w[RD_BIT];
        s.wr_lock = w[WR_BIT];
        s.lg      = w[LG_LSB +: LG_W];
        s.base    = w[BASE_MSB:BASE_LSB];
        return s;
    endfunction

    // ones above the span size; the low bits are don't-care
    function automatic idx_t span_mask(input logic [LG_W-1:0] lg);
        idx_t m;
        if (int'(lg) >= IDX_W) m = '0;
        else                   m = ~idx_t'(0) << lg;
        return m;
    endfunction

    function automatic logic covers(input slot_t s, input idx_t idx);
        return ((idx ^ s.base) & span_mask(s.lg)) == '0;
    endfunction

    function automatic logic denies(input slot_t s, input logic wr);
        return s.wr_lock & (wr | s.rd_lock);
    endfunction

endpackage

// File: rtl/regguard_table.sv
module regguard_table
    import regguard_pkg::*;
#(
    parameter int NUM_SLOTS  = 12,
    parameter int CFG_SLOT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_SLOT_W-1:0]         cfg_slot,
    input  logic [WORD_W-1:0]             cfg_word,
    output slot_t [NUM_SLOTS-1:0]         slots
);

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
    } tab_t;

    tab_t  tab_d, tab_q;
    slot_t new_slot;

    // bits of the word that carry no meaning
    logic unused_word_bits;
    assign unused_word_bits = ^{cfg_word[WORD_W-1], cfg_word[LG_LSB-1:BASE_MSB+1],
                                cfg_word[BASE_LSB-1:0]};

    assign new_slot = unpack_word(cfg_word);

    always_comb begin
        tab_d = tab_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (cfg_we && (int'(cfg_slot) == s)) begin
                tab_d.slot[s] = new_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign slots = tab_q.slot;

endmodule

// File: rtl/regguard_match.sv
module regguard_match
    import regguard_pkg::*;
#(
    parameter int NUM_SLOTS = 12
) (
    input  slot_t [NUM_SLOTS-1:0] slots,
    input  idx_t                  req_idx,
    input  logic                  req_write,
    output logic [NUM_SLOTS-1:0]  deny_vec,
    output logic                  deny
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        assign deny_vec[g] = covers(slots[g], req_idx) & denies(slots[g], req_write);
    end

    assign deny = |deny_vec;

endmodule

// File: rtl/regguard_report.sv
module regguard_report
    import regguard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  idx_t req_idx,
    input  logic req_write,
    input  logic deny,
    input  logic sticky_clr,
    output logic rsp_valid,
    output logic rsp_block,
    output logic fault_pulse,
    output idx_t fault_idx,
    output logic fault_write,
    output logic fault_sticky
);

    typedef struct packed {
        logic rsp_valid;
        logic rsp_block;
        logic fault;
        idx_t fault_idx;
        logic fault_write;
        logic sticky;
    } rpt_t;

    rpt_t rpt_d, rpt_q;
    logic refuse;

    assign refuse = req_valid & deny;

    always_comb begin
        rpt_d           = rpt_q;
        rpt_d.rsp_valid = req_valid;
        rpt_d.rsp_block = refuse;
        rpt_d.fault     = refuse;
        if (refuse) begin
            rpt_d.fault_idx   = req_idx;
            rpt_d.fault_write = req_write;
        end
        rpt_d.sticky = refuse | (rpt_q.sticky & ~sticky_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rpt_q <= '0;
        else        rpt_q <= rpt_d;
    end

    assign rsp_valid    = rpt_q.rsp_valid;
    assign rsp_block    = rpt_q.rsp_block;
    assign fault_pulse  = rpt_q.fault;
    assign fault_idx    = rpt_q.fault_idx;
    assign fault_write  = rpt_q.fault_write;
    assign fault_sticky = rpt_q.sticky;

endmodule

// File: rtl/regguard_top.sv
module regguard_top
    import regguard_pkg::*;
#(
    parameter int NUM_SLOTS  = 12,
    parameter int CFG_SLOT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_SLOT_W-1:0] cfg_slot,
    input  logic [31:0]           cfg_word,
    input  logic                  req_valid,
    input  logic [17:0]           req_idx,
    input  logic                  req_write,
    input  logic                  sticky_clr,
    output logic                  rsp_valid,
    output logic                  rsp_block,
    output logic                  fault_pulse,
    output logic [17:0]           fault_idx,
    output logic                  fault_write,
    output logic                  fault_sticky
);

    slot_t [NUM_SLOTS-1:0] slots;
    logic  [NUM_SLOTS-1:0] deny_vec;
    logic                  deny;

    regguard_table #(
        .NUM_SLOTS  (NUM_SLOTS),
        .CFG_SLOT_W (CFG_SLOT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_word (cfg_word),
        .slots    (slots)
    );

    regguard_match #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_match (
        .slots     (slots),
        .req_idx   (req_idx),
        .req_write (req_write),
        .deny_vec  (deny_vec),
        .deny      (deny)
    );

    regguard_report u_report (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_idx      (req_idx),
        .req_write    (req_write),
        .deny         (deny),
        .sticky_clr   (sticky_clr),
        .rsp_valid    (rsp_valid),
        .rsp_block    (rsp_block),
        .fault_pulse  (fault_pulse),
        .fault_idx    (fault_idx),
        .fault_write  (fault_write),
        .fault_sticky (fault_sticky)
    );

endmodule

// File: rtl/regguard_chk.sv
module regguard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [17:0] req_idx,
    input logic        req_write,
    input logic        sticky_clr,
    input logic        rsp_valid,
    input logic        rsp_block,
    input logic        fault_pulse,
    input logic [17:0] fault_idx,
    input logic        fault_write,
    input logic        fault_sticky
);

    // R7
    rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7
    no_rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    block_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_block |-> rsp_valid);

    // R8
    fault_with_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> rsp_block);

    // R8
    fault_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!fault_pulse || (fault_idx == $past(req_idx) && fault_write == $past(req_write))));

    // R8
    no_fault_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !fault_pulse);

    // R9
    sticky_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> fault_sticky);

    // R9
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_sticky) |-> $past(sticky_clr));

endmodule

bind regguard_top regguard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_idx      (req_idx),
    .req_write    (req_write),
    .sticky_clr   (sticky_clr),
    .rsp_valid    (rsp_valid),
    .rsp_block    (rsp_block),
    .fault_pulse  (fault_pulse),
    .fault_idx    (fault_idx),
    .fault_write  (fault_write),
    .fault_sticky (fault_sticky)
);

// File: tb/regguard_top_test.sv
`timescale 1ns/1ps
module regguard_top_test;

    localparam int NS  = 6;
    localparam int CSW = 3;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           cfg_we = 0;
    logic [CSW-1:0] cfg_slot = '0;
    logic [31:0]    cfg_word = '0;
    logic           req_valid = 0;
    logic [17:0]    req_idx = '0;
    logic           req_write = 0;
    logic           sticky_clr = 0;
    logic           rsp_valid, rsp_block, fault_pulse, fault_write, fault_sticky;
    logic [17:0]    fault_idx;

    int total = 0;
    int bad = 0;
    logic [31:0] model [NS];
    logic sticky_exp = 0;

    always #4 clk = ~clk;

    regguard_top #(.NUM_SLOTS(NS), .CFG_SLOT_W(CSW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_word(cfg_word), .req_valid(req_valid), .req_idx(req_idx),
        .req_write(req_write), .sticky_clr(sticky_clr), .rsp_valid(rsp_valid),
        .rsp_block(rsp_block), .fault_pulse(fault_pulse), .fault_idx(fault_idx),
        .fault_write(fault_write), .fault_sticky(fault_sticky)
    );

    function automatic logic [31:0] mk(input logic rd, input logic wr,
                                       input int lg, input int idx);
        return (32'(rd) << 30) | (32'(wr) << 29) | ((32'(lg) & 32'h1F) << 24) |
               ((32'(idx) & 32'h3FFFF) << 2);
    endfunction

    function automatic logic exp_blk(input logic [17:0] idx, input logic wr);
        logic r = 0;
        for (int s = 0; s < NS; s++) begin
            int          lg   = int'(model[s][28:24]);
            logic [17:0] base = model[s][19:2];
            logic [17:0] m    = (lg >= 18) ? 18'd0 : (18'h3FFFF << lg);
            if ((((idx ^ base) & m) == 18'd0) && model[s][29] && (wr || model[s][30]))
                r = 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int slot, input logic [31:0] w);
        cfg_we = 1; cfg_slot = CSW'(slot); cfg_word = w;
        @(negedge clk);
        cfg_we = 0;
        if (slot < NS) model[slot] = w;
    endtask

    task automatic req(input int idx, input logic wr);
        req_valid = 1; req_idx = 18'(idx); req_write = wr;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_rsp(input string tag, input int idx, input logic wr, input logic blk);
        check({tag, " valid"}, 32'(rsp_valid), 1);
        check({tag, " block"}, 32'(rsp_block), 32'(blk));
        check({tag, " pulse"}, 32'(fault_pulse), 32'(blk));
        if (blk) begin
            check({tag, " fidx"}, 32'(fault_idx), 32'(idx) & 32'h3FFFF);
            check({tag, " fwr"}, 32'(fault_write), 32'(wr));
        end
    endtask

    task automatic access(input string tag, input int idx, input logic wr, input logic blk);
        req(idx, wr);
        expect_rsp(tag, idx, wr, blk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int s = 0; s < NS; s++) model[s] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 rsp_block", 32'(rsp_block), 0);
        check("R1 fault_pulse", 32'(fault_pulse), 0);
        check("R1 sticky", 32'(fault_sticky), 0);
        rst_n = 1;
        @(negedge clk);
        access("R1 empty write", 18'h3FFFF, 1, 0);
        access("R1 empty read", 0, 0, 0);
        // R7 idle cycle
        @(negedge clk);
        check("R7 idle valid", 32'(rsp_valid), 0);

        // R5 misaligned base 7, length 4 -> 4..7, write lock only
        cfg(0, mk(0, 1, 2, 7));
        access("R5 low edge", 4, 1, 1);
        check("R9 sticky set", 32'(fault_sticky), 1);
        access("R5 high edge", 7, 1, 1);
        access("R5 above", 8, 1, 0);
        access("R5 below", 3, 1, 0);
        access("R3 read open", 5, 0, 0);
        @(negedge clk);
        check("R8 pulse gone", 32'(fault_pulse), 0);
        check("R8 idx held", 32'(fault_idx), 7);
        check("R9 sticky held", 32'(fault_sticky), 1);
        sticky_clr = 1; @(negedge clk); sticky_clr = 0;
        check("R9 sticky cleared", 32'(fault_sticky), 0);
        // R9 set wins over clear
        sticky_clr = 1; req_valid = 1; req_idx = 18'd6; req_write = 1;
        @(negedge clk);
        sticky_clr = 0; req_valid = 0;
        check("R9 set wins", 32'(fault_sticky), 1);

        // R2 junk bits ignored; R4 full lock 0x20..0x2F
        cfg(1, mk(1, 1, 4, 'h23) | 32'h80F00003);
        access("R4 read locked", 'h2F, 0, 1);
        access("R2 read outside", 'h30, 0, 0);
        access("R2 write locked", 'h20, 1, 1);
        // R4 bit 30 alone never blocks
        cfg(2, mk(1, 0, 3, 'h100));
        access("R4 rd-only read", 'h100, 0, 0);
        access("R4 rd-only write", 'h107, 1, 0);
        // R6 overlap: open slot does not override locking slot
        cfg(5, mk(1, 0, 0, 'h21));
        access("R6 overlap", 'h21, 0, 1);
        // R5 full range, then R12 removal
        cfg(3, mk(0, 1, 31, 'h155));
        access("R5 full range", 'h3FFFF, 1, 1);
        access("R5 full range read", 'h3FFFF, 0, 0);
        cfg(3, 32'h0);
        access("R12 removed", 'h3FFFF, 1, 0);
        // R10 nonexistent slots
        cfg(6, mk(1, 1, 31, 0));
        cfg(7, mk(1, 1, 31, 0));
        access("R10 slot6/7 read", 'h3000, 0, 0);
        access("R10 slot6/7 write", 'h3000, 1, 0);
        // R11 same-cycle write sees old table
        cfg_we = 1; cfg_slot = 3'd4; cfg_word = mk(1, 1, 0, 'h500);
        req_valid = 1; req_idx = 18'h500; req_write = 0;
        @(negedge clk);
        cfg_we = 0; req_valid = 0; model[4] = mk(1, 1, 0, 'h500);
        expect_rsp("R11 old table", 'h500, 0, 0);
        access("R11 new table", 'h500, 0, 1);

        // random phase
        sticky_clr = 1; @(negedge clk); sticky_clr = 0;
        sticky_exp = 0;
        for (int i = 0; i < 600; i++) begin
            int r = int'($urandom % 4);
            if (r == 0) begin
                int lgr = int'($urandom % 10);
                int lg  = (lgr == 9) ? 18 + int'($urandom % 14) : lgr;
                cfg(int'($urandom % 8),
                    mk(1'($urandom), 1'($urandom), lg, int'($urandom % 512)) |
                    ($urandom & 32'h80F00003));
            end else begin
                int   idx = int'($urandom % 512);
                logic wr  = 1'($urandom);
                logic e   = exp_blk(18'(idx), wr);
                access("R6 random", idx, wr, e);
                sticky_exp = sticky_exp | e;
                check("R9 random sticky", 32'(fault_sticky), 32'(sticky_exp));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule